// File: doc/BRIEF.md
# Collective Tree Step Scheduler

This block tells one core of a power-of-two group what to do at one step of a tree-shaped collective. It takes the core's index, the group's depth N (2^N cores), the step number, the kind of collective and a combine operator. It answers with the peer core, the role at this step (send, receive or stay idle) and the operator that applies. It also merges the eight 32-bit lanes of an incoming payload with the core's own lanes, so the caller gets the updated local data in the same result.

Two tree collectives are supported. A reduce gathers every core's data into core 0 over N steps. A broadcast spreads core 0's data to all cores over N steps, using the same pairs in the opposite order. There are also two point-to-point kinds, where the caller names the peer directly. A request is taken on any clock edge where `in_valid` is high. The answer appears, registered, one cycle later. The network that carries the payload lies outside this block.

Top module: `coll_step_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0, `out_role` is IDLE (0), `out_peer` is 0 and `out_data` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high. All outputs describe that request.
- R3: Kind REDUCE (0), step k: a core whose bit k is 1 and whose bits below k are 0 gets role SEND (1) with peer = core − 2^k. A core whose bits k and below are all 0 gets role RECV (2) with peer = core + 2^k. Every other core gets IDLE with peer 0.
- R4: Kind BROADCAST (1), step s: use the pairing of R3 at level k = N−1−s, with the roles exchanged. The core with bit k set and the lower bits clear is RECV. The core with bits k and below clear is SEND.
- R5: For REDUCE or BROADCAST, the result is IDLE with peer 0 when any of these hold: step ≥ N, N > the width of the core index, or the core index is ≥ 2^N.
- R6: Kind SEND (2) gives role SEND, and kind RECV (3) gives role RECV. In both cases `out_peer` equals `in_peer`, whatever the depth and the step.
- R7: On a receive with operator ADD (0), each lane is local + received, modulo 2^32.
- R8: On a receive with operator MIN (1) or MAX (2), each lane takes the smaller or larger value, with both values read as signed 32-bit integers.
- R9: `out_op` equals `in_op`, except for kind BROADCAST, where it is COPY (3). On a receive with COPY, each lane becomes the received lane.
- R10: When the role is not RECV, `out_data` equals `in_local` unchanged. Lane i occupies bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 2 | 0 reduce, 1 broadcast, 2 point-to-point send, 3 point-to-point receive |
| in_op | input | 2 | 0 add, 1 signed min, 2 signed max, 3 copy |
| in_depth | input | 3 | Tree depth N (group of 2^N cores) |
| in_step | input | 3 | Step index, 0 first |
| in_core | input | 5 | This core's index within the group |
| in_peer | input | 5 | Explicit peer for point-to-point kinds |
| in_local | input | 256 | Local lanes |
| in_recv | input | 256 | Received lanes |
| out_valid | output | 1 | Result valid |
| out_role | output | 2 | 0 idle, 1 send, 2 receive |
| out_peer | output | 5 | Peer core index |
| out_op | output | 2 | Operator in effect |
| out_data | output | 256 | Local lanes after the combine |

## Verification
The pairing is tried at every level of an eight-core tree, with each role appearing both at the edge of the group and at the root. This separates a shift by the right amount from one that is off by one level. Broadcast entries use the mirrored level, so a step order or a role swap that was not applied shows up as the wrong peer. Steps equal to N, cores above the group, a depth of zero and the widest depth catch faulty range tests. The lane data mixes signs and values near the limits, so wrap-around addition and signed-versus-unsigned min/max give different answers.

// File: rtl/coll_pkg.sv
package coll_pkg;

    typedef enum logic [1:0] {
        KIND_REDUCE = 2'd0,
        KIND_BCAST  = 2'd1,
        KIND_SEND   = 2'd2,
        KIND_RECV   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MIN  = 2'd1,
        OP_MAX  = 2'd2,
        OP_COPY = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ROLE_IDLE = 2'd0,
        ROLE_SEND = 2'd1,
        ROLE_RECV = 2'd2
    } role_e;

    function automatic op_e effective_op(kind_e k, op_e o);
        return (k == KIND_BCAST) ? OP_COPY : o;
    endfunction

endpackage

// File: rtl/coll_role_gen.sv
module coll_role_gen
    import coll_pkg::*;
#(
    parameter int ID_W  = 5,
    parameter int DEP_W = 3
) (
    input  kind_e              kind,
    input  logic [DEP_W-1:0]   depth,
    input  logic [DEP_W-1:0]   step,
    input  logic [ID_W-1:0]    core,
    input  logic [ID_W-1:0]    peer_in,
    output role_e              role,
    output logic [ID_W-1:0]    peer
);
    logic             in_range;
    logic [DEP_W-1:0] level;
    logic [ID_W-1:0]  bit_k;
    logic [ID_W-1:0]  below;
    logic             is_upper;
    logic             is_lower;

    always_comb begin
        in_range = (step < depth) && (depth <= DEP_W'(ID_W))
                   && ((core >> depth) == '0);
        level    = (kind == KIND_BCAST) ? (depth - step - DEP_W'(1)) : step;
        bit_k    = ID_W'(1) << level;
        below    = bit_k - ID_W'(1);
        is_upper = ((core & bit_k) != '0) && ((core & below) == '0);
        is_lower = ((core & (bit_k | below)) == '0);
    end

    always_comb begin
        role = ROLE_IDLE;
        peer = '0;
        unique case (kind)
            KIND_SEND: begin
                role = ROLE_SEND;
                peer = peer_in;
            end
            KIND_RECV: begin
                role = ROLE_RECV;
                peer = peer_in;
            end
            default: begin
                if (in_range && is_upper) begin
                    role = (kind == KIND_REDUCE) ? ROLE_SEND : ROLE_RECV;
                    peer = core - bit_k;
                end else if (in_range && is_lower) begin
                    role = (kind == KIND_REDUCE) ? ROLE_RECV : ROLE_SEND;
                    peer = core + bit_k;
                end
            end
        endcase
    end
endmodule

// File: rtl/coll_lane_combine.sv
module coll_lane_combine
    import coll_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 32
) (
    input  op_e                        op,
    input  logic                       take,
    input  logic [LANES*LANE_W-1:0]    local_d,
    input  logic [LANES*LANE_W-1:0]    recv_d,
    output logic [LANES*LANE_W-1:0]    merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] a;
        logic [LANE_W-1:0] b;
        logic [LANE_W-1:0] r;
        logic              a_lt_b;
        assign a      = local_d[g*LANE_W +: LANE_W];
        assign b      = recv_d[g*LANE_W +: LANE_W];
        assign a_lt_b = $signed(a) < $signed(b);
        always_comb begin
            unique case (op)
                OP_ADD:  r = a + b;
                OP_MIN:  r = a_lt_b ? a : b;
                OP_MAX:  r = a_lt_b ? b : a;
                default: r = b;
            endcase
        end
        assign merged[g*LANE_W +: LANE_W] = take ? r : a;
    end
endmodule

// File: rtl/coll_step_sched.sv
module coll_step_sched
    import coll_pkg::*;
#(
    parameter int ID_W   = 5,
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    localparam int DEP_W = $clog2(ID_W + 1),
    localparam int DAT_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [1:0]       in_op,
    input  logic [DEP_W-1:0] in_depth,
    input  logic [DEP_W-1:0] in_step,
    input  logic [ID_W-1:0]  in_core,
    input  logic [ID_W-1:0]  in_peer,
    input  logic [DAT_W-1:0] in_local,
    input  logic [DAT_W-1:0] in_recv,
    output logic             out_valid,
    output logic [1:0]       out_role,
    output logic [ID_W-1:0]  out_peer,
    output logic [1:0]       out_op,
    output logic [DAT_W-1:0] out_data
);
    kind_e            kind;
    op_e              op_eff;
    role_e            role_c;
    logic [ID_W-1:0]  peer_c;
    logic [DAT_W-1:0] data_c;

    assign kind   = kind_e'(in_kind);
    assign op_eff = effective_op(kind, op_e'(in_op));

    coll_role_gen #(.ID_W(ID_W), .DEP_W(DEP_W)) role_i (
        .kind    (kind),
        .depth   (in_depth),
        .step    (in_step),
        .core    (in_core),
        .peer_in (in_peer),
        .role    (role_c),
        .peer    (peer_c)
    );

    coll_lane_combine #(.LANES(LANES), .LANE_W(LANE_W)) comb_i (
        .op      (op_eff),
        .take    (role_c == ROLE_RECV),
        .local_d (in_local),
        .recv_d  (in_recv),
        .merged  (data_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_role  <= ROLE_IDLE;
            out_peer  <= '0;
            out_op    <= OP_ADD;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_role <= role_c;
                out_peer <= peer_c;
                out_op   <= op_eff;
                out_data <= data_c;
            end
        end
    end
endmodule

// File: rtl/coll_step_sched_chk.sv
module coll_step_sched_chk #(
    parameter int ID_W   = 5,
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    localparam int DEP_W = $clog2(ID_W + 1),
    localparam int DAT_W = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_kind,
    input logic [1:0]       in_op,
    input logic [ID_W-1:0]  in_core,
    input logic [ID_W-1:0]  in_peer,
    input logic [DAT_W-1:0] in_local,
    input logic             out_valid,
    input logic [1:0]       out_role,
    input logic [ID_W-1:0]  out_peer,
    input logic [1:0]       out_op,
    input logic [DAT_W-1:0] out_data
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_role_legal_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_role != 2'd3);
    p_send_downward_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd0) |=> (out_role != 2'd1 || out_peer < $past(in_core)));
    p_root_never_sends_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd0 && in_core == '0) |=> out_role != 2'd1);
    p_bcast_recv_upward_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd1) |=> (out_role != 2'd2 || out_peer < $past(in_core)));
    p_p2p_peer_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind[1]) |=> out_peer == $past(in_peer));
    p_bcast_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd1) |=> out_op == 2'd3);
    p_other_op_echo_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind != 2'd1) |=> out_op == $past(in_op));
    p_passthrough_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_role == 2'd2 || out_data == $past(in_local)));
endmodule

bind coll_step_sched coll_step_sched_chk #(.ID_W(ID_W), .LANES(LANES), .LANE_W(LANE_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_op(in_op),
    .in_core(in_core), .in_peer(in_peer), .in_local(in_local),
    .out_valid(out_valid), .out_role(out_role), .out_peer(out_peer),
    .out_op(out_op), .out_data(out_data)
);

// File: tb/coll_step_sched_tb_top.sv
module coll_step_sched_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   in_kind, in_op;
    logic [2:0]   in_depth, in_step;
    logic [4:0]   in_core, in_peer;
    logic [255:0] in_local, in_recv;
    logic         out_valid;
    logic [1:0]   out_role, out_op;
    logic [4:0]   out_peer;
    logic [255:0] out_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    coll_step_sched dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_op(in_op),
        .in_depth(in_depth), .in_step(in_step), .in_core(in_core), .in_peer(in_peer),
        .in_local(in_local), .in_recv(in_recv), .out_valid(out_valid),
        .out_role(out_role), .out_peer(out_peer), .out_op(out_op), .out_data(out_data)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] op;
        logic [2:0] dep;
        logic [2:0] step;
        logic [4:0] core;
        logic [4:0] peer;
        logic [1:0] role;
        logic [4:0] xpeer;
    } vec_t;

    localparam int NV = 22;
    // kind, op, N, step, core, peer_in, expected role, expected peer
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd0, 3'd3, 3'd0, 5'd1,  5'd0,  2'd1, 5'd0},  // R3
        '{2'd0, 2'd0, 3'd3, 3'd0, 5'd0,  5'd0,  2'd2, 5'd1},  // R3
        '{2'd0, 2'd1, 3'd3, 3'd0, 5'd2,  5'd0,  2'd2, 5'd3},  // R3
        '{2'd0, 2'd2, 3'd3, 3'd0, 5'd7,  5'd0,  2'd1, 5'd6},  // R3
        '{2'd0, 2'd0, 3'd3, 3'd1, 5'd2,  5'd0,  2'd1, 5'd0},  // R3
        '{2'd0, 2'd0, 3'd3, 3'd1, 5'd1,  5'd0,  2'd0, 5'd0},  // R3
        '{2'd0, 2'd2, 3'd3, 3'd1, 5'd4,  5'd0,  2'd2, 5'd6},  // R3
        '{2'd0, 2'd1, 3'd3, 3'd2, 5'd4,  5'd0,  2'd1, 5'd0},  // R3
        '{2'd0, 2'd3, 3'd3, 3'd2, 5'd0,  5'd0,  2'd2, 5'd4},  // R3
        '{2'd0, 2'd0, 3'd3, 3'd2, 5'd6,  5'd0,  2'd0, 5'd0},  // R3
        '{2'd1, 2'd0, 3'd3, 3'd0, 5'd0,  5'd0,  2'd1, 5'd4},  // R4
        '{2'd1, 2'd1, 3'd3, 3'd0, 5'd4,  5'd0,  2'd2, 5'd0},  // R4
        '{2'd1, 2'd0, 3'd3, 3'd0, 5'd2,  5'd0,  2'd0, 5'd0},  // R4
        '{2'd1, 2'd2, 3'd3, 3'd2, 5'd5,  5'd0,  2'd2, 5'd4},  // R4
        '{2'd1, 2'd0, 3'd3, 3'd2, 5'd4,  5'd0,  2'd1, 5'd5},  // R4
        '{2'd0, 2'd0, 3'd3, 3'd3, 5'd0,  5'd0,  2'd0, 5'd0},  // R5
        '{2'd0, 2'd0, 3'd3, 3'd0, 5'd9,  5'd0,  2'd0, 5'd0},  // R5
        '{2'd1, 2'd0, 3'd0, 3'd0, 5'd0,  5'd0,  2'd0, 5'd0},  // R5
        '{2'd0, 2'd0, 3'd6, 3'd0, 5'd1,  5'd0,  2'd0, 5'd0},  // R5
        '{2'd0, 2'd2, 3'd5, 3'd4, 5'd16, 5'd0,  2'd1, 5'd0},  // R3
        '{2'd2, 2'd0, 3'd0, 3'd7, 5'd3,  5'd17, 2'd1, 5'd17}, // R6
        '{2'd3, 2'd1, 3'd0, 3'd7, 5'd3,  5'd22, 2'd2, 5'd22}  // R6
    };

    function automatic logic [31:0] lane_model(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return ($signed(a) <= $signed(b)) ? a : b;
            2'd2:    return ($signed(a) >= $signed(b)) ? a : b;
            default: return b;
        endcase
    endfunction

    function automatic logic [255:0] data_model(logic [1:0] role, logic [1:0] op,
                                                 logic [255:0] loc, logic [255:0] rcv);
        logic [255:0] r = loc;
        if (role == 2'd2)
            for (int i = 0; i < 8; i++)
                r[32*i +: 32] = lane_model(op, loc[32*i +: 32], rcv[32*i +: 32]);
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] kind, logic [1:0] op, logic [2:0] dep, logic [2:0] step,
                         logic [4:0] core, logic [4:0] peer, logic [255:0] loc, logic [255:0] rcv);
        @(negedge clk);
        in_valid = 1'b1; in_kind = kind; in_op = op; in_depth = dep; in_step = step;
        in_core = core; in_peer = peer; in_local = loc; in_recv = rcv;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [255:0] loc, rcv, exp_d;
        logic [1:0]   xop;
        rst = 1'b1; in_valid = 1'b0; in_kind = '0; in_op = '0; in_depth = '0;
        in_step = '0; in_core = '0; in_peer = '0; in_local = '0; in_recv = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 256'(out_valid), 256'd0);
        check("R1 role in reset", 256'(out_role), 256'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 256'(out_valid), 256'd0);
        check("R1 peer after reset", 256'(out_peer), 256'd0);
        check("R1 data after reset", out_data, 256'd0);

        for (int j = 0; j < NV; j++) begin
            for (int i = 0; i < 8; i++) begin
                loc[32*i +: 32] = 32'(j * 32'h1357_9BDF + i * 32'h9E37_79B9);
                rcv[32*i +: 32] = 32'(~(j * 32'h0246_8ACE) + i * 32'h7F4A_7C15);
            end
            apply(VT[j].kind, VT[j].op, VT[j].dep, VT[j].step, VT[j].core, VT[j].peer, loc, rcv);
            xop   = (VT[j].kind == 2'd1) ? 2'd3 : VT[j].op;
            exp_d = data_model(VT[j].role, xop, loc, rcv);
            check("R2 valid", 256'(out_valid), 256'd1);
            check("R3/R4/R5/R6 role", 256'(out_role), 256'(VT[j].role));
            check("R3/R4/R5/R6 peer", 256'(out_peer), 256'(VT[j].xpeer));
            check("R9 op", 256'(out_op), 256'(xop));
            check("R7/R8/R10 data", out_data, exp_d);
        end
        @(negedge clk);
        check("R2 valid drops", 256'(out_valid), 256'd0);

        // R7: add wraps
        loc = '0; rcv = '0;
        loc[31:0] = 32'hFFFF_FFFF; rcv[31:0] = 32'd2;
        loc[63:32] = 32'h8000_0000; rcv[63:32] = 32'h8000_0000;
        apply(2'd3, 2'd0, 3'd0, 3'd0, 5'd0, 5'd1, loc, rcv);
        check("R7 wrap lane0", 256'(out_data[31:0]), 256'd1);
        check("R7 wrap lane1", 256'(out_data[63:32]), 256'd0);

        // R8: signed min / max
        loc[31:0] = 32'hFFFF_FFFF; rcv[31:0] = 32'd5;
        loc[63:32] = 32'h8000_0000; rcv[63:32] = 32'd1;
        apply(2'd3, 2'd1, 3'd0, 3'd0, 5'd0, 5'd1, loc, rcv);
        check("R8 min signed", 256'(out_data[31:0]), 256'hFFFF_FFFF);
        check("R8 min negative extreme", 256'(out_data[63:32]), 256'h8000_0000);
        apply(2'd0, 2'd2, 3'd1, 3'd0, 5'd0, 5'd0, loc, rcv);
        check("R8 max signed", 256'(out_data[31:0]), 256'd5);
        check("R8 max over extreme", 256'(out_data[63:32]), 256'd1);

        // R9: broadcast receive copies even with ADD requested
        apply(2'd1, 2'd0, 3'd1, 3'd0, 5'd1, 5'd0, loc, rcv);
        check("R9 bcast op", 256'(out_op), 256'd3);
        check("R9 bcast copy", out_data, rcv);

        // R10: idle and send keep local data
        apply(2'd2, 2'd0, 3'd0, 3'd0, 5'd4, 5'd9, loc, rcv);
        check("R10 send keeps local", out_data, loc);

        // R1: reset mid-run clears outputs
        apply(2'd3, 2'd0, 3'd0, 3'd0, 5'd1, 5'd2, loc, rcv);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears valid", 256'(out_valid), 256'd0);
        check("R1 reset clears role", 256'(out_role), 256'd0);
        rst = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule